// File: doc/BRIEF.md
# Bus Master Latency Timer

This block decides when a bus master that is running a burst must hand the bus back. The host programs an 8-bit guaranteed-ownership time through a small write port, and the value can be read back at any time. When the master raises its own FRAME at the start of an ownership period, the programmed value is taken into a down-counter. The counter then loses one per clock and stops at zero.

The release decision combines that count with the arbiter's grant. While the count is non-zero, the master keeps transferring even if the grant has gone away. Once the count is zero and the grant is low, the block tells the master engine to let go. While FRAME is low the counter is held at zero, so only bursts are affected. A single-cycle address-only transfer is never cut short.

A register write made during a burst is stored for the next ownership period and leaves the running count alone. Hard reset clears the programmed value. No other event touches it.

Top module: `bm_latency_timer`

## Requirements
- R1: `cfg_rd_data` shows the programmed 8-bit value, and all eight bits are writable. A write with `cfg_wr_en` high is visible on `cfg_rd_data` from the cycle after the write clock edge.
- R2: A burst starts in a cycle where `own_frame` is high and was low in the previous cycle. In that start cycle the remaining time equals the programmed value held before that clock edge.
- R3: While `own_frame` stays high, the remaining time decreases by one per clock until it reaches zero. It then stays at zero and never wraps.
- R4: While `own_frame` is high and the remaining time is non-zero, `must_release` stays low whatever `bus_grant` does.
- R5: `must_release` is high in every cycle where `own_frame` is high, `bus_grant` is low and the remaining time is zero. With a programmed value L and grant low from the start, it first rises L cycles after the start cycle.
- R6: While `own_frame` is low, the counter is cleared and `must_release` is low. Each rise of `own_frame` therefore starts a fresh count.
- R7: Active-low `rst_n` clears the programmed value to 0. Apart from a write, nothing changes the value.
- R8: A write made during a burst changes only the value loaded at the next start. A write in the start cycle itself does not affect the count loaded in that cycle.
- R9: With a programmed value of 0, `must_release` is high in the first burst cycle in which `bus_grant` is low, including the start cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| cfg_wr_en | input | 1 | Write strobe for the timer value |
| cfg_wr_data | input | 8 | Timer value to write |
| cfg_rd_data | output | 8 | Current programmed timer value |
| own_frame | input | 1 | Master is asserting FRAME |
| bus_grant | input | 1 | Arbiter grant to this master |
| must_release | output | 1 | Master has to give up the bus now |

## Verification
Two events can land in the same cycle: a register write and the start of a burst (FRAME rising). The bench provokes this by raising FRAME in the very cycle that writes a new value, with the grant low. It then checks that release comes after the old value's number of cycles, and that the following burst uses the new value. A second collision is grant loss in the start cycle while the programmed value is zero. Here release is required in that same cycle. The reference model computes the expected output for every cycle, and each clock's result is compared against it.

// File: rtl/busown_pkg.sv
package busown_pkg;

   localparam int LT_DEFAULT_W = 8;

   typedef enum logic {
      LT_OUT_COMB = 1'b0,
      LT_OUT_REG  = 1'b1
   } lt_out_mode_e;

endpackage

// File: rtl/lt_timer_reg.sv
module lt_timer_reg #(
   parameter int           W       = busown_pkg::LT_DEFAULT_W,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] value_o
);

   logic [W-1:0] value_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       value_q <= RST_VAL;
      else if (wr_en_i) value_q <= wr_data_i;
   end

   assign value_o = value_q;

   // R7: the value holds unless a write occurs
   assert_reg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(value_q));

   // R1: a write is visible on the next cycle
   assert_reg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> value_q == $past(wr_data_i));

endmodule

// File: rtl/lt_burst_counter.sv
module lt_burst_counter #(
   parameter int W = busown_pkg::LT_DEFAULT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_i,
   input  logic [W-1:0] load_val_i,
   output logic         start_o,
   output logic [W-1:0] remaining_o
);

   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ZERO = '0;

   logic         frame_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic         start;

   assign start       = frame_i & ~frame_q;
   assign remaining_o = start ? load_val_i : cnt_q;
   assign start_o     = start;

   always_comb begin
      if (!frame_i)                cnt_d = ZERO;
      else if (remaining_o != ZERO) cnt_d = remaining_o - ONE;
      else                         cnt_d = ZERO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= 1'b0;
         cnt_q   <= ZERO;
      end else begin
         frame_q <= frame_i;
         cnt_q   <= cnt_d;
      end
   end

   // R6: an idle cycle leaves the counter cleared
   assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_i |=> cnt_q == ZERO);

   // R3: once at zero inside a burst, the count stays at zero
   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == ZERO && !start) |=> cnt_q == ZERO);

   // R3 / R8: the running count steps down by one, and register writes do not disturb it
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && !start && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);

   // R2: the start cycle takes the programmed value
   assert_load_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && load_val_i != ZERO) |=> cnt_q == $past(load_val_i) - ONE);

endmodule

// File: rtl/lt_release_decide.sv
module lt_release_decide #(
   parameter int                       W        = busown_pkg::LT_DEFAULT_W,
   parameter busown_pkg::lt_out_mode_e OUT_MODE = busown_pkg::LT_OUT_COMB
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_i,
   input  logic         gnt_i,
   input  logic [W-1:0] remaining_i,
   output logic         release_o
);

   logic expired;
   logic want_release;

   assign expired      = (remaining_i == '0);
   assign want_release = frame_i & ~gnt_i & expired;

   generate
      if (OUT_MODE == busown_pkg::LT_OUT_REG) begin : g_out_reg
         logic rel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rel_q <= 1'b0;
            else        rel_q <= want_release;
         end
         assign release_o = rel_q;
      end else begin : g_out_comb
         assign release_o = want_release;

         // R6: no release request outside a burst
         assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_i |-> !release_o);

         // R4: the bus is kept while time remains
         assert_keep_while_counting_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_i && !expired) |-> !release_o);
      end
   endgenerate

endmodule

// File: rtl/bm_latency_timer.sv
module bm_latency_timer #(
   parameter int                       TIMER_W  = busown_pkg::LT_DEFAULT_W,
   parameter logic [TIMER_W-1:0]       RST_VAL  = '0,
   parameter busown_pkg::lt_out_mode_e OUT_MODE = busown_pkg::LT_OUT_COMB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [TIMER_W-1:0] cfg_wr_data,
   output logic [TIMER_W-1:0] cfg_rd_data,
   input  logic               own_frame,
   input  logic               bus_grant,
   output logic               must_release
);

   generate
      if (TIMER_W < 1 || TIMER_W > 32) begin : g_bad_width
         $error("bm_latency_timer: TIMER_W must lie in 1..32");
      end
   endgenerate

   logic [TIMER_W-1:0] timer_val;
   logic [TIMER_W-1:0] remaining;
   logic               burst_start;

   lt_timer_reg #(
      .W       (TIMER_W),
      .RST_VAL (RST_VAL)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (cfg_wr_en),
      .wr_data_i (cfg_wr_data),
      .value_o   (timer_val)
   );

   lt_burst_counter #(
      .W (TIMER_W)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_i     (own_frame),
      .load_val_i  (timer_val),
      .start_o     (burst_start),
      .remaining_o (remaining)
   );

   lt_release_decide #(
      .W        (TIMER_W),
      .OUT_MODE (OUT_MODE)
   ) u_rel (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_i     (own_frame),
      .gnt_i       (bus_grant),
      .remaining_i (remaining),
      .release_o   (must_release)
   );

   assign cfg_rd_data = timer_val;

   generate
      if (OUT_MODE == busown_pkg::LT_OUT_COMB) begin : g_top_checks
         // R9: a zero setting releases in the start cycle when the grant is already gone
         assert_zero_setting_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (burst_start && !bus_grant && timer_val == '0) |-> must_release);

         // R5: an expired count with no grant releases the bus
         assert_release_expired_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (own_frame && !bus_grant && !burst_start && $past(own_frame) && $past(remaining) <= 1)
            |-> must_release);
      end
   endgenerate

endmodule

// File: tb/bm_latency_timer_test.sv
module bm_latency_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_wr_data = '0;
   logic [7:0] cfg_rd_data;
   logic       own_frame = 1'b0;
   logic       bus_grant = 1'b1;
   logic       must_release;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int m_reg  = 0;
   int m_cnt  = 0;
   bit m_prev = 0;

   always #4 clk = ~clk;

   bm_latency_timer uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_data  (cfg_wr_data),
      .cfg_rd_data  (cfg_rd_data),
      .own_frame    (own_frame),
      .bus_grant    (bus_grant),
      .must_release (must_release)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // drive one cycle, compare against the model, advance the model at the edge
   task automatic step(input bit f, input bit g, input bit we, input int d, input string tag);
      bit start;
      int rem;
      bit exp_rel;
      @(negedge clk);
      own_frame   = f;
      bus_grant   = g;
      cfg_wr_en   = we;
      cfg_wr_data = 8'(d);
      #1;
      start   = f && !m_prev;
      rem     = start ? m_reg : m_cnt;
      exp_rel = f && !g && (rem == 0);
      check(must_release == exp_rel, {tag, " release"}, int'(must_release), int'(exp_rel));
      check(int'(cfg_rd_data) == m_reg, {tag, " readback"}, int'(cfg_rd_data), m_reg);
      @(posedge clk);
      if (!f)           m_cnt = 0;
      else if (rem > 0) m_cnt = rem - 1;
      else              m_cnt = 0;
      if (we) m_reg = d & 255;
      m_prev = f;
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      own_frame = 0; bus_grant = 1; cfg_wr_en = 0;
      rst_n = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(cfg_rd_data == 8'd0, {tag, " reg cleared"}, int'(cfg_rd_data), 0);
      check(must_release == 1'b0, {tag, " no release in reset"}, int'(must_release), 0);
      rst_n = 1;
      m_reg = 0; m_cnt = 0; m_prev = 0;
   endtask

   initial begin
      do_reset("R7 initial");

      // R1: write and read back
      step(0, 1, 1, 5, "R1 write");
      step(0, 1, 0, 0, "R1 readback");
      step(0, 1, 1, 8'hA5, "R1 all bits");
      step(0, 1, 1, 5, "R1 rewrite");

      // R2 R4 R5: burst with L=5, grant dropped before expiry
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R2 burst granted");
      for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R4 R5 grant lost");
      step(0, 0, 0, 0, "R6 frame ends");

      // R6: idle with grant low, then single-cycle frames
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R6 idle");
      for (int i = 0; i < 4; i++) begin
         step(1, 0, 0, 0, "R6 pulse");
         step(0, 0, 0, 0, "R6 gap");
      end

      // R8: write during a burst does not alter the running count
      for (int i = 0; i < 2; i++) step(1, 0, 0, 0, "R8 burst");
      step(1, 0, 1, 3, "R8 mid write");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R8 old count");
      step(0, 1, 0, 0, "R8 gap");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R8 new count");
      step(0, 1, 0, 0, "R8 gap2");

      // R8: write in the start cycle itself
      step(1, 0, 1, 9, "R8 same cycle");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R8 same cycle run");
      step(0, 1, 0, 0, "R8 gap3");
      for (int i = 0; i < 11; i++) step(1, 0, 0, 0, "R8 next burst");
      step(0, 1, 0, 0, "R8 gap4");

      // R9: zero setting
      step(0, 1, 1, 0, "R9 write zero");
      step(1, 0, 0, 0, "R9 start no grant");
      step(1, 0, 0, 0, "R9 hold");
      step(0, 1, 0, 0, "R9 gap");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R9 granted");
      step(1, 0, 0, 0, "R9 grant lost");
      step(1, 1, 0, 0, "R9 grant back");
      step(0, 1, 0, 0, "R9 gap2");

      // R3: maximum setting saturates at zero
      step(0, 1, 1, 255, "R3 write max");
      for (int i = 0; i < 262; i++) step(1, (i % 7) == 0, 0, 0, "R3 saturate");
      step(0, 1, 0, 0, "R3 end");

      // R7: hard reset mid-burst clears the register
      step(0, 1, 1, 7, "R7 write");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R7 burst");
      do_reset("R7 mid burst");
      step(1, 0, 0, 0, "R7 after reset zero");
      step(0, 1, 0, 0, "R7 end");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule